// File: doc/BRIEF.md
# DRAM Reset and Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory channel. It owns the memory's active-low master reset and walks the device through the start-up steps before normal traffic may begin. It holds the reset pin low for a minimum pulse width, waits a settling interval, loads the four mode registers, and issues one long impedance-calibration command. It then waits out the calibration window and raises a ready flag. The pulse width is long after a power-up and short after a re-initialization requested while the system is up. Every wait is a clock count set by a parameter.

The block also derives the latency settings from a clock-period code and a DLL-off configuration bit. It encodes them into the mode-register payloads and presents them as plain outputs for the rest of the controller. Commands leave on a valid/ready interface. While `cmd_valid` is high and `cmd_ready` is low, the command and its payload stay unchanged. A command is consumed on a clock edge where both are high. The downstream side may stall for any number of cycles. Additive latency is fixed at zero.

A low `pwr_good` resets the block asynchronously and marks the next pulse as a power-up pulse. A one-cycle `reinit_req` starts a warm re-initialization from any state.

Top module: `dram_init_seq`

## Requirements
- R1: While `pwr_good` is low, `mem_rst_n`, `init_done`, `cmd_valid` and `cfg_err` are all low. After `pwr_good` rises, `mem_rst_n` goes high on exactly the RST_COLD_CYC-th rising clock edge.
- R2: A `reinit_req` sampled high drives `mem_rst_n` low on that edge. `mem_rst_n` returns high RST_WARM_CYC edges later, and the full sequence follows.
- R3: The first command becomes valid exactly POST_RST_CYC edges after `mem_rst_n` rises. No command is valid while `mem_rst_n` is low.
- R4: Commands go out in this order: bank 2, bank 3, bank 1, bank 0 (mode-register loads, `cmd_zqcl`=0), then one long calibration (`cmd_zqcl`=1, `cmd_ba`=0, address bit 10 set, all other address bits 0). The payload is held stable while stalled. The next command becomes valid exactly MOD_CYC edges after the previous one was accepted.
- R5: `init_done` rises exactly ZQ_CYC edges after the calibration command is accepted. It is low from any reset assertion until then.
- R6: With the DLL on, the write latency follows `tck_code`: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. The bank-2 payload carries write latency minus 5 in address bits 5:3, with all other bits 0.
- R7: With the DLL on, the CAS latency is 6, 7, 9 or 11 for codes 0 to 3, and the read latency equals it. The bank-0 payload carries CAS latency minus 4 in bits 6:4, bit 8 set (DLL reset), all other bits 0. The bank-1 payload is bit 2 only (termination on). The bank-3 payload is zero.
- R8: With `dll_off` high, `tck_code` is ignored and no error is raised. CAS latency and write latency are both 6 and read latency is 5. The bank-1 payload is bit 0 only (DLL disabled, termination off). Bit 8 of the bank-0 payload is clear.
- R9: With the DLL on, a `tck_code` of 4 to 7 at reset release raises `cfg_err` and releases `mem_rst_n`. No command is issued and `init_done` stays low until a `reinit_req`.
- R10: A `reinit_req` in mid-sequence aborts the sequence. `mem_rst_n` goes low with the warm pulse width, and the sequence restarts from the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| pwr_good | input | 1 | Supply good; low acts as asynchronous reset and selects the power-up pulse width |
| reinit_req | input | 1 | One-cycle request for a warm re-initialization |
| tck_code | input | 3 | Clock-period range code, sampled when reset is released |
| dll_off | input | 1 | DLL-off configuration, sampled when reset is released |
| mem_rst_n | output | 1 | Active-low master reset to the memory |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted when high together with cmd_valid |
| cmd_zqcl | output | 1 | 1 = long calibration, 0 = mode-register load |
| cmd_ba | output | 3 | Bank address (mode-register select) |
| cmd_addr | output | ADDR_W | Address bus payload |
| init_done | output | 1 | Memory ready for normal traffic |
| cfg_err | output | 1 | Unsupported clock-period code |
| cas_lat | output | 5 | Selected CAS latency, zero until configuration is accepted |
| cas_wr_lat | output | 5 | Selected write latency, zero until configuration is accepted |
| rd_lat | output | 6 | Effective read latency, zero until configuration is accepted |

## Verification
The assertions assume that `pwr_good` drops only as a deliberate reset. They also assume that `cmd_ready` may change freely, including while a command is offered. Both `tck_code` and `dll_off` are taken as settled before reset is released. The bench changes the configuration only before starting a sequence and drives every input at the falling edge. It sweeps all eight codes in both DLL modes, mixing cold and warm starts. It varies the stall length on each command and places a warm request in mid-sequence and in the error state.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [2:0] {
    ST_RST_HOLD,
    ST_STABLE,
    ST_ISSUE,
    ST_GAP,
    ST_ZQ_WAIT,
    ST_READY,
    ST_FAULT
  } seq_st_t;

  localparam int unsigned SLOT_N = 5;
  localparam int unsigned SLOT_W = 3;

  // Mode-register load order; the last slot is the calibration command
  function automatic logic [2:0] slot_bank(input logic [SLOT_W-1:0] slot);
    logic [2:0] b;
    case (slot)
      3'd0:    b = 3'd2;
      3'd1:    b = 3'd3;
      3'd2:    b = 3'd1;
      default: b = 3'd0;
    endcase
    return b;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dinit_lat_map.sv
module dinit_lat_map (
  input  logic [2:0] tck_code,
  input  logic       dll_off,
  output logic [4:0] cl,
  output logic [4:0] cwl,
  output logic [5:0] rl,
  output logic       ok
);
  always_comb begin
    ok  = 1'b1;
    cl  = 5'd6;
    cwl = 5'd6;
    if (!dll_off) begin
      case (tck_code)
        3'd0: begin cl = 5'd6;  cwl = 5'd5; end
        3'd1: begin cl = 5'd7;  cwl = 5'd6; end
        3'd2: begin cl = 5'd9;  cwl = 5'd7; end
        3'd3: begin cl = 5'd11; cwl = 5'd8; end
        default: ok = 1'b0;
      endcase
    end
    // slow-clock mode returns data one cycle earlier than the CAS setting
    rl = dll_off ? ({1'b0, cl} - 6'd1) : {1'b0, cl};
  end
endmodule

// File: rtl/dinit_timer.sv
module dinit_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dinit_mr_gen.sv
module dinit_mr_gen
  import dinit_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [4:0]        cl,
  input  logic [4:0]        cwl,
  input  logic              dll_off,
  output logic              zqcl,
  output logic [2:0]        ba,
  output logic [ADDR_W-1:0] addr
);
  logic [4:0] cl_fld;
  logic [4:0] cwl_fld;

  always_comb begin
    cl_fld  = cl - 5'd4;
    cwl_fld = cwl - 5'd5;
    addr    = '0;
    zqcl    = 1'b0;
    ba      = slot_bank(slot);
    case (slot)
      3'd0: addr[5:3] = cwl_fld[2:0];
      3'd2: begin
        addr[0] = dll_off;
        addr[2] = ~dll_off;
      end
      3'd3: begin
        addr[6:4] = cl_fld[2:0];
        addr[8]   = ~dll_off;
      end
      3'd4: begin
        zqcl     = 1'b1;
        addr[10] = 1'b1;
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dinit_pkg::*;
#(
  parameter int unsigned ADDR_W       = 14,
  parameter int unsigned RST_COLD_CYC = 160000,
  parameter int unsigned RST_WARM_CYC = 80,
  parameter int unsigned POST_RST_CYC = 400000,
  parameter int unsigned MOD_CYC      = 12,
  parameter int unsigned ZQ_CYC       = 512
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              reinit_req,
  input  logic [2:0]        tck_code,
  input  logic              dll_off,
  output logic              mem_rst_n,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_zqcl,
  output logic [2:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              init_done,
  output logic              cfg_err,
  output logic [4:0]        cas_lat,
  output logic [4:0]        cas_wr_lat,
  output logic [5:0]        rd_lat
);
  localparam int unsigned MAX_WAIT = max_of(max_of(RST_COLD_CYC, RST_WARM_CYC),
                                            max_of(POST_RST_CYC, max_of(MOD_CYC, ZQ_CYC)));
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);

  seq_st_t           st_q, st_d;
  logic              cold_q;
  logic              rst_q;
  logic [SLOT_W-1:0] slot_q;
  logic              dll_q;
  logic [4:0]        cl_q, cwl_q;
  logic [5:0]        rl_q;
  logic [CNT_W-1:0]  cnt, last;
  logic              expire, clear;
  logic [4:0]        map_cl, map_cwl;
  logic [5:0]        map_rl;
  logic              map_ok;

  dinit_lat_map u_map (
    .tck_code (tck_code),
    .dll_off  (dll_off),
    .cl       (map_cl),
    .cwl      (map_cwl),
    .rl       (map_rl),
    .ok       (map_ok)
  );

  dinit_timer #(.W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (pwr_good),
    .clear (clear),
    .cnt   (cnt)
  );

  dinit_mr_gen #(.ADDR_W(ADDR_W)) u_mr (
    .slot    (slot_q),
    .cl      (cl_q),
    .cwl     (cwl_q),
    .dll_off (dll_q),
    .zqcl    (cmd_zqcl),
    .ba      (cmd_ba),
    .addr    (cmd_addr)
  );

  // one shared timer, its terminal count chosen by the current state
  always_comb begin
    case (st_q)
      ST_RST_HOLD: last = cold_q ? CNT_W'(RST_COLD_CYC - 1) : CNT_W'(RST_WARM_CYC - 1);
      ST_STABLE:   last = CNT_W'(POST_RST_CYC - 1);
      ST_GAP:      last = CNT_W'(MOD_CYC - 1);
      ST_ZQ_WAIT:  last = CNT_W'(ZQ_CYC - 1);
      default:     last = '0;
    endcase
  end

  assign expire = (cnt == last);

  always_comb begin
    st_d = st_q;
    if (reinit_req) begin
      st_d = ST_RST_HOLD;
    end else begin
      case (st_q)
        ST_RST_HOLD: if (expire) st_d = map_ok ? ST_STABLE : ST_FAULT;
        ST_STABLE:   if (expire) st_d = ST_ISSUE;
        ST_ISSUE:    if (cmd_ready)
                       st_d = (slot_q == SLOT_W'(SLOT_N - 1)) ? ST_ZQ_WAIT : ST_GAP;
        ST_GAP:      if (expire) st_d = ST_ISSUE;
        ST_ZQ_WAIT:  if (expire) st_d = ST_READY;
        default:     st_d = st_q;
      endcase
    end
  end

  assign clear = reinit_req || (st_d != st_q);

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      st_q   <= ST_RST_HOLD;
      cold_q <= 1'b1;
      rst_q  <= 1'b0;
      slot_q <= '0;
      dll_q  <= 1'b0;
      cl_q   <= '0;
      cwl_q  <= '0;
      rl_q   <= '0;
    end else begin
      st_q  <= st_d;
      rst_q <= (st_d != ST_RST_HOLD);
      if (reinit_req) cold_q <= 1'b0;
      if (st_d == ST_RST_HOLD)
        slot_q <= '0;
      else if (st_q == ST_ISSUE && st_d == ST_GAP)
        slot_q <= slot_q + 1'b1;
      if (st_q == ST_RST_HOLD && st_d == ST_STABLE) begin
        dll_q <= dll_off;
        cl_q  <= map_cl;
        cwl_q <= map_cwl;
        rl_q  <= map_rl;
      end else if (st_d == ST_RST_HOLD || st_d == ST_FAULT) begin
        dll_q <= 1'b0;
        cl_q  <= '0;
        cwl_q <= '0;
        rl_q  <= '0;
      end
    end
  end

  assign mem_rst_n  = rst_q;
  assign cmd_valid  = (st_q == ST_ISSUE);
  assign init_done  = (st_q == ST_READY);
  assign cfg_err    = (st_q == ST_FAULT);
  assign cas_lat    = cl_q;
  assign cas_wr_lat = cwl_q;
  assign rd_lat     = rl_q;

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              pwr_good,
  input logic              reinit_req,
  input logic              mem_rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_zqcl,
  input logic [2:0]        cmd_ba,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              init_done,
  input logic              cfg_err,
  input logic [4:0]        cas_lat,
  input logic [4:0]        cas_wr_lat,
  input logic [5:0]        rd_lat
);
  // R5
  rst_gates_out_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !mem_rst_n |-> (!init_done && !cmd_valid));

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (cmd_valid && !cmd_ready && !reinit_req) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_ba) && $stable(cmd_zqcl)));

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    cfg_err |-> (!init_done && !cmd_valid && mem_rst_n));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    reinit_req |=> (!mem_rst_n && !init_done && !cmd_valid));

  // R6
  cwl_range_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    init_done |-> (cas_wr_lat >= 5'd5 && cas_wr_lat <= 5'd8));

  // R8
  rl_rel_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    init_done |-> ((rd_lat == {1'b0, cas_lat}) || ((rd_lat + 6'd1) == {1'b0, cas_lat})));
endmodule

bind dram_init_seq dram_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .pwr_good   (pwr_good),
  .reinit_req (reinit_req),
  .mem_rst_n  (mem_rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_zqcl   (cmd_zqcl),
  .cmd_ba     (cmd_ba),
  .cmd_addr   (cmd_addr),
  .init_done  (init_done),
  .cfg_err    (cfg_err),
  .cas_lat    (cas_lat),
  .cas_wr_lat (cas_wr_lat),
  .rd_lat     (rd_lat)
);

// File: tb/dram_init_seq_test.sv
module dram_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 14;
  localparam int COLD = 40;
  localparam int WARM = 8;
  localparam int POST = 10;
  localparam int MOD  = 4;
  localparam int ZQ   = 512;

  logic          clk = 1'b0;
  logic          pwr_good = 1'b0;
  logic          reinit_req = 1'b0;
  logic [2:0]    tck_code = '0;
  logic          dll_off = 1'b0;
  logic          mem_rst_n, cmd_valid, cmd_zqcl, init_done, cfg_err;
  logic          cmd_ready = 1'b0;
  logic [2:0]    cmd_ba;
  logic [AW-1:0] cmd_addr;
  logic [4:0]    cas_lat, cas_wr_lat;
  logic [5:0]    rd_lat;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_init_seq #(
    .ADDR_W(AW), .RST_COLD_CYC(COLD), .RST_WARM_CYC(WARM),
    .POST_RST_CYC(POST), .MOD_CYC(MOD), .ZQ_CYC(ZQ)
  ) uut (
    .clk(clk), .pwr_good(pwr_good), .reinit_req(reinit_req),
    .tck_code(tck_code), .dll_off(dll_off), .mem_rst_n(mem_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_zqcl(cmd_zqcl),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .init_done(init_done),
    .cfg_err(cfg_err), .cas_lat(cas_lat), .cas_wr_lat(cas_wr_lat),
    .rd_lat(rd_lat)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cl(input int code, input bit dll);
    if (dll) return 6;
    case (code)
      0: return 6;
      1: return 7;
      2: return 9;
      default: return 11;
    endcase
  endfunction

  function automatic int exp_cwl(input int code, input bit dll);
    return dll ? 6 : 5 + code;
  endfunction

  function automatic int exp_ba(input int k);
    case (k)
      0: return 2;
      1: return 3;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_addr(input int k, input int cl, input int cwl, input bit dll);
    case (k)
      0: return (cwl - 5) << 3;
      1: return 0;
      2: return dll ? 1 : 4;
      3: return ((cl - 4) << 4) | (dll ? 0 : 256);
      default: return 1024;
    endcase
  endfunction

  task automatic start_cold();
    int n;
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rst low", int'(mem_rst_n), 0);
    chk("R1 done low", int'(init_done), 0);
    chk("R1 valid low", int'(cmd_valid), 0);
    chk("R1 err low", int'(cfg_err), 0);
    pwr_good = 1'b1;
    n = 0;
    while (!mem_rst_n) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk("R1 cold width", n, COLD);
  endtask

  task automatic start_warm(input string tag);
    int n;
    @(negedge clk);
    reinit_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reinit_req = 1'b0;
    chk({tag, " rst low"}, int'(mem_rst_n), 0);
    chk({tag, " R5 done low"}, int'(init_done), 0);
    chk({tag, " valid low"}, int'(cmd_valid), 0);
    n = 0;
    while (!mem_rst_n) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk({tag, " warm width"}, n, WARM);
  endtask

  task automatic wait_first_cmd();
    int n = 0;
    while (!cmd_valid) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk("R3 settle", n, POST);
  endtask

  task automatic finish_seq(input int code, input bit dll);
    int cl = exp_cl(code, dll);
    int cwl = exp_cwl(code, dll);
    string ltag = dll ? "R8" : "R7";
    if (!dll && code > 3) begin
      repeat (2) @(negedge clk);
      chk("R9 err", int'(cfg_err), 1);
      chk("R9 done", int'(init_done), 0);
      chk("R9 valid", int'(cmd_valid), 0);
      chk("R9 rst high", int'(mem_rst_n), 1);
      return;
    end
    chk("R8 no err", int'(cfg_err), 0);
    wait_first_cmd();
    for (int k = 0; k < 5; k++) begin
      int hold = (k + code) % 3;
      int a0 = int'(cmd_addr);
      int n;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk("R4 stall valid", int'(cmd_valid), 1);
        chk("R4 stall addr", int'(cmd_addr), a0);
      end
      chk("R4 order ba", int'(cmd_ba), exp_ba(k));
      chk("R4 kind", int'(cmd_zqcl), (k == 4) ? 1 : 0);
      chk(k == 0 ? "R6 payload" : (k == 2 || dll) ? "R8 payload" : "R7 payload",
          int'(cmd_addr), exp_addr(k, cl, cwl, dll));
      cmd_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_ready = 1'b0;
      chk("R4 valid drops", int'(cmd_valid), 0);
      n = 0;
      if (k < 4) begin
        while (!cmd_valid) begin
          @(posedge clk); n++; @(negedge clk);
        end
        chk("R4 spacing", n, MOD);
      end else begin
        while (!init_done) begin
          @(posedge clk); n++; @(negedge clk);
        end
        chk("R5 cal window", n, ZQ);
      end
    end
    chk("R6 cwl", int'(cas_wr_lat), cwl);
    chk({ltag, " cl"}, int'(cas_lat), cl);
    chk({ltag, " rl"}, int'(rd_lat), dll ? 5 : cl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tck_code = 3'd0;
    dll_off  = 1'b0;
    start_cold();
    finish_seq(0, 1'b0);
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 8; c++) begin
        tck_code = 3'(c);
        dll_off  = d[0];
        if (c == 3 || c == 6) start_cold();
        else start_warm("R2");
        finish_seq(c, d[0]);
      end
    end
    // abort in mid-sequence
    tck_code = 3'd2;
    dll_off  = 1'b0;
    start_warm("R2");
    wait_first_cmd();
    cmd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_ready = 1'b0;
    start_warm("R10");
    finish_seq(2, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule